// File: doc/BRIEF.md
# Fault Mitigation Escalation Controller

This block gathers fault reports from the whole fault-detection layer of an embedded processing platform and turns them into exactly one recovery request at a time. The reports come from the error correctors on three protected memories, the dual-processor comparator, the processor watchdog, two system bus monitors and the configuration integrity checker. The block classifies each report into one of four severities: processor interrupt, processor reset, system reset or device reconfiguration. It then pulses the matching action output. While the action is outstanding, the current severity stays visible on `level_o`.

Recoveries that keep coming back escalate. Every processor reset that is issued is counted. Once that count is full, the next processor-class fault becomes a system reset. System resets are counted in the same way, and when that count is full the next system-class action becomes a reconfiguration. A counter clears after a quiet interval in which its class sees no fault. After each action the controller waits for an acknowledge, or for a timeout, and then returns to normal. Faults that arrive during that wait are dropped.

The fault detectors and the execution of the recovery actions are outside this block.

Top module: `fault_escalation_ctrl`

## Requirements
- R1: During reset and on its release, all four action outputs are low and `level_o` is 0.
- R2: A single-bit error on any bit of `mem_sbe_i`, with no higher fault present, gives a one-cycle `cpu_irq_o` pulse in the cycle after it is sampled, and `level_o` becomes 1.
- R3: A processor mismatch, a watchdog expiry or an on-chip memory double-bit error gives a `cpu_rst_o` pulse with `level_o` = 2, unless R7 escalates it.
- R4: An error on either bit of `bus_err_i` gives a `sys_rst_o` pulse with `level_o` = 3, unless R8 escalates it.
- R5: A configuration check failure, or a double-bit error in program memory or external memory, gives a `reconfig_o` pulse with `level_o` = 4.
- R6: When faults of several classes are sampled in the same cycle, only the highest severity acts. The order from highest is reconfiguration, system reset, processor reset, interrupt.
- R7: After CPU_LIMIT processor resets have been counted, the next processor-class fault gives a system reset instead, and the processor count clears.
- R8: After SYS_LIMIT system resets have been counted, the next system reset, whether direct or escalated, becomes a reconfiguration. Any reconfiguration clears both counts.
- R9: A count clears once QUIET_CYCLES consecutive cycles pass with no fault of its class and no increment.
- R10: At most one action output is high in any cycle, and no action output is high for two cycles in a row.
- R11: While `level_o` is nonzero, no new action is issued and sampled faults are dropped. An `ack_i` sampled in this state returns `level_o` to 0 on the next cycle.
- R12: Without an acknowledge, `level_o` returns to 0 exactly ACK_TIMEOUT cycles after the action pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_sbe_i | input | 3 | Single-bit error reports, one per protected memory |
| cpu_mismatch_i | input | 1 | Dual-processor comparator mismatch |
| wdog_expire_i | input | 1 | Processor watchdog expiry |
| ocm_dbe_i | input | 1 | On-chip memory double-bit error |
| bus_err_i | input | 2 | Bus error reports, one per system bus |
| cfg_crc_fail_i | input | 1 | Configuration check failure |
| prog_dbe_i | input | 1 | Program memory double-bit error |
| ext_dbe_i | input | 1 | External memory double-bit error |
| ack_i | input | 1 | Recovery complete acknowledge |
| cpu_irq_o | output | 1 | Processor interrupt pulse |
| cpu_rst_o | output | 1 | Processor reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| reconfig_o | output | 1 | Device reconfiguration pulse |
| level_o | output | 3 | Severity in progress: 0 normal, 1 interrupt, 2 processor reset, 3 system reset, 4 reconfiguration |

## Verification
The bound checker watches several properties on every cycle. It enforces that the action pulses are exclusive and last one cycle, that each pulse agrees with the severity reported beside it, and that no action starts while a severity is outstanding. It also checks that a reconfiguration-class fault in the normal state always yields a reconfiguration, and that an acknowledge returns the block to normal. The escalation counts, their clearing by quiet intervals, and the exact timeout release depend on long histories. Only the bench scenarios can show these, by comparing each cycle against a reference model and through the directed sequences.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int unsigned NUM_MEM = 3;
  localparam int unsigned NUM_BUS = 2;

  typedef enum logic [2:0] {
    SEV_NONE = 3'd0,
    SEV_IRQ  = 3'd1,
    SEV_CPU  = 3'd2,
    SEV_SYS  = 3'd3,
    SEV_RCFG = 3'd4
  } sev_e;
endpackage

// File: rtl/fe_classify.sv
module fe_classify
  import fe_pkg::*;
(
  input  logic [NUM_MEM-1:0] mem_sbe_i,
  input  logic               cpu_mismatch_i,
  input  logic               wdog_expire_i,
  input  logic               ocm_dbe_i,
  input  logic [NUM_BUS-1:0] bus_err_i,
  input  logic               cfg_crc_fail_i,
  input  logic               prog_dbe_i,
  input  logic               ext_dbe_i,
  output sev_e               cls_o,
  output logic               cpu_seen_o,
  output logic               sys_seen_o
);
  logic irq_seen, rcfg_seen;

  assign irq_seen   = |mem_sbe_i;
  assign cpu_seen_o = cpu_mismatch_i | wdog_expire_i | ocm_dbe_i;
  assign sys_seen_o = |bus_err_i;
  assign rcfg_seen  = cfg_crc_fail_i | prog_dbe_i | ext_dbe_i;

  always_comb begin
    if (rcfg_seen)       cls_o = SEV_RCFG;
    else if (sys_seen_o) cls_o = SEV_SYS;
    else if (cpu_seen_o) cls_o = SEV_CPU;
    else if (irq_seen)   cls_o = SEV_IRQ;
    else                 cls_o = SEV_NONE;
  end
endmodule

// File: rtl/fe_esc_counter.sv
module fe_esc_counter #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned QUIET = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic class_seen_i,
  input  logic inc_i,
  input  logic clr_i,
  output logic full_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam int unsigned QW = (QUIET > 2) ? $clog2(QUIET) : 1;

  logic [CW-1:0] cnt_q;
  logic [QW-1:0] quiet_q;
  logic          quiet_done;

  assign quiet_done = !class_seen_i && !inc_i && (quiet_q == QW'(QUIET - 1));
  assign full_o     = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      quiet_q <= '0;
    end else begin
      if (class_seen_i || inc_i || quiet_done) quiet_q <= '0;
      else                                     quiet_q <= quiet_q + 1'b1;
      if (clr_i || quiet_done) cnt_q <= '0;
      else if (inc_i)          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fe_ack_tracker.sv
module fe_ack_tracker #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic [TW-1:0] tmo_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (ack_i || tmo_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmo_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tmo_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      tmo_q  <= '0;
    end else if (busy_q) begin
      tmo_q  <= tmo_q + 1'b1;
    end
  end
endmodule

// File: rtl/fault_escalation_ctrl.sv
module fault_escalation_ctrl
  import fe_pkg::*;
#(
  parameter int unsigned CPU_LIMIT    = 4,
  parameter int unsigned SYS_LIMIT    = 4,
  parameter int unsigned QUIET_CYCLES = 64,
  parameter int unsigned ACK_TIMEOUT  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MEM-1:0] mem_sbe_i,
  input  logic               cpu_mismatch_i,
  input  logic               wdog_expire_i,
  input  logic               ocm_dbe_i,
  input  logic [NUM_BUS-1:0] bus_err_i,
  input  logic               cfg_crc_fail_i,
  input  logic               prog_dbe_i,
  input  logic               ext_dbe_i,
  input  logic               ack_i,
  output logic               cpu_irq_o,
  output logic               cpu_rst_o,
  output logic               sys_rst_o,
  output logic               reconfig_o,
  output logic [2:0]         level_o
);
  sev_e cls, act, level_q;
  logic cpu_seen, sys_seen, cpu_full, sys_full;
  logic busy, done, accept;
  logic cpu_inc, cpu_clr, sys_inc, sys_clr;
  logic [3:0] pulse_q;

  fe_classify u_cls (
    .mem_sbe_i      (mem_sbe_i),
    .cpu_mismatch_i (cpu_mismatch_i),
    .wdog_expire_i  (wdog_expire_i),
    .ocm_dbe_i      (ocm_dbe_i),
    .bus_err_i      (bus_err_i),
    .cfg_crc_fail_i (cfg_crc_fail_i),
    .prog_dbe_i     (prog_dbe_i),
    .ext_dbe_i      (ext_dbe_i),
    .cls_o          (cls),
    .cpu_seen_o     (cpu_seen),
    .sys_seen_o     (sys_seen)
  );

  fe_esc_counter #(.LIMIT(CPU_LIMIT), .QUIET(QUIET_CYCLES)) u_cpu_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .class_seen_i (cpu_seen),
    .inc_i        (cpu_inc),
    .clr_i        (cpu_clr),
    .full_o       (cpu_full)
  );

  fe_esc_counter #(.LIMIT(SYS_LIMIT), .QUIET(QUIET_CYCLES)) u_sys_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .class_seen_i (sys_seen),
    .inc_i        (sys_inc),
    .clr_i        (sys_clr),
    .full_o       (sys_full)
  );

  fe_ack_tracker #(.TIMEOUT(ACK_TIMEOUT)) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .ack_i   (ack_i),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign accept = !busy && (cls != SEV_NONE);

  // escalation chain: cpu -> sys -> reconfig, each gated by its full count
  always_comb begin
    act     = cls;
    cpu_clr = 1'b0;
    sys_clr = 1'b0;
    if (act == SEV_CPU && cpu_full) begin
      act     = SEV_SYS;
      cpu_clr = 1'b1;
    end
    if (act == SEV_SYS && sys_full) act = SEV_RCFG;
    if (act == SEV_RCFG) begin
      cpu_clr = 1'b1;
      sys_clr = 1'b1;
    end
    cpu_inc = (act == SEV_CPU);
    sys_inc = (act == SEV_SYS);
    if (!accept) begin
      cpu_clr = 1'b0;
      sys_clr = 1'b0;
      cpu_inc = 1'b0;
      sys_inc = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= SEV_NONE;
      pulse_q <= '0;
    end else begin
      pulse_q <= '0;
      if (accept) begin
        level_q <= act;
        pulse_q <= 4'(1 << (act - 1));
      end else if (done) begin
        level_q <= SEV_NONE;
      end
    end
  end

  assign cpu_irq_o  = pulse_q[0];
  assign cpu_rst_o  = pulse_q[1];
  assign sys_rst_o  = pulse_q[2];
  assign reconfig_o = pulse_q[3];
  assign level_o    = level_q;
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_crc_fail_i,
  input logic       prog_dbe_i,
  input logic       ext_dbe_i,
  input logic       ack_i,
  input logic       cpu_irq_o,
  input logic       cpu_rst_o,
  input logic       sys_rst_o,
  input logic       reconfig_o,
  input logic [2:0] level_o
);
  logic [3:0] pulses;
  assign pulses = {reconfig_o, sys_rst_o, cpu_rst_o, cpu_irq_o};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (pulses == 4'd0 && level_o == 3'd0);
    end
  end

  assert_irq_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> level_o == 3'd1);
  assert_cpu_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> level_o == 3'd2);
  assert_sys_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> level_o == 3'd3);
  assert_rcfg_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reconfig_o |-> level_o == 3'd4);
  assert_rcfg_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 3'd0 && (cfg_crc_fail_i || prog_dbe_i || ext_dbe_i)) |=> reconfig_o);
  assert_one_hot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulses));
  assert_single_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulses) |=> pulses == 4'd0);
  assert_no_issue_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulses) |-> $past(level_o) == 3'd0);
  assert_ack_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != 3'd0 && ack_i) |=> level_o == 3'd0);
endmodule

bind fault_escalation_ctrl fe_checker u_fe_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_crc_fail_i (cfg_crc_fail_i),
  .prog_dbe_i     (prog_dbe_i),
  .ext_dbe_i      (ext_dbe_i),
  .ack_i          (ack_i),
  .cpu_irq_o      (cpu_irq_o),
  .cpu_rst_o      (cpu_rst_o),
  .sys_rst_o      (sys_rst_o),
  .reconfig_o     (reconfig_o),
  .level_o        (level_o)
);

// File: tb/fault_escalation_ctrl_test.sv
module fault_escalation_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU_LIM = 4;
  localparam int SYS_LIM = 4;
  localparam int QUIET   = 64;
  localparam int ACK_TO  = 16;

  // fault vector: [2:0] mem sbe, [3] mismatch, [4] watchdog, [5] ocm dbe,
  // [7:6] bus errors, [8] cfg fail, [9] prog dbe, [10] ext dbe
  localparam logic [10:0] F_IRQ  = 11'h001;
  localparam logic [10:0] F_CPU  = 11'h008;
  localparam logic [10:0] F_BUS  = 11'h040;
  localparam logic [10:0] F_RCFG = 11'h100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [10:0] flt = '0;
  logic ack_i = 1'b0;
  logic cpu_irq_o, cpu_rst_o, sys_rst_o, reconfig_o;
  logic [2:0] level_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_busy;
  int m_tmo, m_level, m_cpu, m_sys, m_qc, m_qs;
  logic [3:0] e_pulse;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_escalation_ctrl #(
    .CPU_LIMIT(CPU_LIM), .SYS_LIMIT(SYS_LIM),
    .QUIET_CYCLES(QUIET), .ACK_TIMEOUT(ACK_TO)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mem_sbe_i(flt[2:0]), .cpu_mismatch_i(flt[3]), .wdog_expire_i(flt[4]),
    .ocm_dbe_i(flt[5]), .bus_err_i(flt[7:6]), .cfg_crc_fail_i(flt[8]),
    .prog_dbe_i(flt[9]), .ext_dbe_i(flt[10]), .ack_i(ack_i),
    .cpu_irq_o(cpu_irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o),
    .reconfig_o(reconfig_o), .level_o(level_o)
  );

  function automatic int class_of(input logic [10:0] f);
    if (|f[10:8]) return 4;
    if (|f[7:6])  return 3;
    if (|f[5:3])  return 2;
    if (|f[2:0])  return 1;
    return 0;
  endfunction

  task automatic model_step(input logic [10:0] f, input logic a);
    int cls, act;
    bit acc, done, cseen, sseen, cinc, sinc, cclr, sclr, cexp, sexp;
    cls = class_of(f);
    cseen = |f[5:3];
    sseen = |f[7:6];
    done = m_busy && (a || m_tmo == ACK_TO - 1);
    acc = !m_busy && cls != 0;
    act = cls; cclr = 0; sclr = 0;
    if (act == 2 && m_cpu == CPU_LIM) begin act = 3; cclr = 1; end
    if (act == 3 && m_sys == SYS_LIM) act = 4;
    if (act == 4) begin cclr = 1; sclr = 1; end
    cinc = (act == 2);
    sinc = (act == 3);
    if (!acc) begin cclr = 0; sclr = 0; cinc = 0; sinc = 0; end
    cexp = !cseen && !cinc && m_qc == QUIET - 1;
    sexp = !sseen && !sinc && m_qs == QUIET - 1;
    m_qc  = (cseen || cinc || cexp) ? 0 : m_qc + 1;
    m_qs  = (sseen || sinc || sexp) ? 0 : m_qs + 1;
    m_cpu = (cclr || cexp) ? 0 : (cinc ? m_cpu + 1 : m_cpu);
    m_sys = (sclr || sexp) ? 0 : (sinc ? m_sys + 1 : m_sys);
    e_pulse = acc ? 4'(1 << (act - 1)) : 4'd0;
    if (acc) begin m_busy = 1; m_tmo = 0; m_level = act; end
    else if (done) begin m_busy = 0; m_tmo = 0; m_level = 0; end
    else if (m_busy) m_tmo = m_tmo + 1;
  endtask

  task automatic check(input string tag, input logic [3:0] ep, input int el);
    logic [3:0] ap;
    ap = {reconfig_o, sys_rst_o, cpu_rst_o, cpu_irq_o};
    checks++;
    if (ap !== ep || level_o !== 3'(el)) begin
      errors++;
      $display("FAIL %s pulses=%b level=%0d expected pulses=%b level=%0d",
               tag, ap, level_o, ep, el);
    end
  endtask

  task automatic cyc(input logic [10:0] f, input logic a, input string tag);
    flt = f;
    ack_i = a;
    model_step(f, a);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, e_pulse, m_level);
  endtask

  task automatic model_reset();
    m_busy = 0; m_tmo = 0; m_level = 0; m_cpu = 0; m_sys = 0; m_qc = 0; m_qs = 0;
    e_pulse = '0;
  endtask

  task automatic do_reset();
    flt = '0; ack_i = 0;
    rst_ni = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    check("R1 reset", 4'd0, 0);
    rst_ni = 1;
  endtask

  // issue a fault then acknowledge it
  task automatic hit(input logic [10:0] f, input string tag);
    cyc(f, 0, tag);
    cyc('0, 1, tag);
    cyc('0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    cyc('0, 0, "R1 idle");
    check("R1 post reset", 4'd0, 0);

    // single sources, each memory / bus bit
    for (int i = 0; i < 3; i++) begin
      cyc(11'(1 << i), 0, "R2 sbe");
      check("R2 irq pulse", 4'b0001, 1);
      cyc('0, 1, "R2 ack"); cyc('0, 0, "R2");
    end
    for (int i = 3; i < 6; i++) begin
      do_reset();
      cyc(11'(1 << i), 0, "R3 cpu class");
      check("R3 cpu reset", 4'b0010, 2);
      cyc('0, 1, "R3 ack"); cyc('0, 0, "R3");
    end
    for (int i = 6; i < 8; i++) begin
      do_reset();
      cyc(11'(1 << i), 0, "R4 bus");
      check("R4 sys reset", 4'b0100, 3);
      cyc('0, 1, "R4 ack"); cyc('0, 0, "R4");
    end
    for (int i = 8; i < 11; i++) begin
      do_reset();
      cyc(11'(1 << i), 0, "R5 rcfg class");
      check("R5 reconfig", 4'b1000, 4);
      cyc('0, 1, "R5 ack"); cyc('0, 0, "R5");
    end

    // simultaneous faults
    do_reset();
    cyc(F_IRQ | F_CPU | F_BUS, 0, "R6 mix");
    check("R6 sys wins", 4'b0100, 3);
    cyc('0, 1, "R6"); cyc('0, 0, "R6");
    cyc(11'h7ff, 0, "R6 all");
    check("R6 rcfg wins", 4'b1000, 4);
    cyc('0, 1, "R6"); cyc('0, 0, "R6");
    cyc(F_IRQ | F_CPU, 0, "R6 pair");
    check("R6 cpu wins", 4'b0010, 2);
    cyc('0, 1, "R6"); cyc('0, 0, "R6");

    // cpu escalation
    do_reset();
    for (int k = 0; k < CPU_LIM; k++) hit(F_CPU, "R7 fill");
    cyc(F_CPU, 0, "R7 escalate");
    check("R7 cpu->sys", 4'b0100, 3);
    cyc('0, 1, "R7"); cyc('0, 0, "R7");
    cyc(F_CPU, 0, "R7 cleared");
    check("R7 count cleared", 4'b0010, 2);
    cyc('0, 1, "R7"); cyc('0, 0, "R7");

    // sys escalation, direct and via cpu chain
    do_reset();
    for (int k = 0; k < SYS_LIM; k++) hit(F_BUS, "R8 fill");
    cyc(F_BUS, 0, "R8 escalate");
    check("R8 sys->rcfg", 4'b1000, 4);
    cyc('0, 1, "R8"); cyc('0, 0, "R8");
    cyc(F_BUS, 0, "R8 cleared");
    check("R8 sys count cleared", 4'b0100, 3);
    cyc('0, 1, "R8"); cyc('0, 0, "R8");
    do_reset();
    for (int k = 0; k < SYS_LIM; k++) hit(F_BUS, "R8 fill2");
    for (int k = 0; k < CPU_LIM; k++) hit(F_CPU, "R8 fill cpu");
    cyc(F_CPU, 0, "R8 chain");
    check("R8 cpu->sys->rcfg", 4'b1000, 4);
    cyc('0, 1, "R8"); cyc('0, 0, "R8");

    // quiet period
    do_reset();
    for (int k = 0; k < CPU_LIM; k++) hit(F_CPU, "R9 fill");
    for (int k = 0; k < QUIET + 2; k++) cyc('0, 0, "R9 quiet");
    cyc(F_CPU, 0, "R9 after quiet");
    check("R9 no escalation", 4'b0010, 2);
    cyc('0, 1, "R9"); cyc('0, 0, "R9");

    // busy drop and ack
    do_reset();
    cyc(F_IRQ, 0, "R11 start");
    cyc(F_RCFG, 0, "R11 busy");
    check("R11 dropped", 4'b0000, 1);
    cyc('0, 1, "R11 ack");
    check("R11 released", 4'b0000, 0);
    cyc('0, 0, "R10");
    check("R10 quiet", 4'b0000, 0);

    // timeout
    do_reset();
    cyc(F_IRQ, 0, "R12 start");
    for (int k = 0; k < ACK_TO - 1; k++) cyc('0, 0, "R12 wait");
    check("R12 still held", 4'b0000, 1);
    cyc('0, 0, "R12 expire");
    check("R12 released", 4'b0000, 0);

    // constrained random
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [10:0] f;
      f = '0;
      if ($urandom % 5 == 0) f = 11'(1 << ($urandom % 11));
      if ($urandom % 12 == 0) f = f | 11'(1 << ($urandom % 11));
      cyc(f, ($urandom % 4 == 0), "R10 random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule